// File: doc/BRIEF.md
# Multi-Line Transmit Byte-Count Engine

This block drives the transmit side of sixteen serial lines from one shared byte-fetch engine. Each line has its own 18-bit buffer address and 16-bit byte count. Software loads the count as the negative of the number of characters to send. Software reaches a line's address and count through a window: a line-select field in the control register chooses which line the address and count registers show. Setting a line's bit in the active mask starts that line.

The engine serves the active lines in turn, one byte fetch per turn. For each fetch it issues a read request on a simple request/acknowledge memory port. It places the returned byte in that line's output slot, which the line's serialiser drains through a valid/ready handshake. After each byte it advances the line's address and moves the count one step toward zero. When the count reaches zero, the engine clears the line's active bit and raises the transmit-done flag. A failed fetch ends the line at once and sets the memory-error flag. A separate break mask holds chosen lines in the spacing state.

Top module: `mltx_engine`

## Requirements
- R1: After reset, every software register reads 0, no memory request is pending, no output slot is valid, and the `brk_o` and `irq_o` outputs are low.
- R2: Register offsets on `reg_addr_i`:
  - Offset 0 is control. Bits 3:0 select a line. Bits 5:4 are bits 17:16 of the selected line's address. A control write also stores its bits 5:4 into the newly selected line.
  - Offset 1 reads and writes bits 15:0 of the selected line's address.
  - Offset 2 reads and writes the selected line's count.
  - Every other line keeps its own values while it is not selected.
- R3: Writing offset 3 sets each active bit whose data bit is 1; data bits of 0 have no effect. For an active line n, the engine fetches bytes starting at its 18-bit address and presents each byte on lane n of `tx_data_o` (bits 8n+7:8n) with `tx_valid_o[n]`. After each byte it adds 1 to the line's address and 1 to its count.
- R4: When a fetch takes a line's count to zero, the engine clears active bit n and sets control bit 15. `irq_o` equals control bit 15 AND control bit 13. A control write with bit 15 at 0 clears the flag; a write with bit 15 at 1 leaves it unchanged.
- R5: A line gets a fetch only while its output slot is empty. A filled slot holds its byte until `tx_ready_i[n]` accepts it.
- R6: Eligible lines are granted one fetch each, in ascending order, starting after the last line granted and wrapping from line 15 to line 0.
- R7: Writing 16'hFFFF to a busy line's count stops that line after at most one more byte. The address register then holds the start address plus the number of bytes sent.
- R8: A fetch acknowledged with `mem_err_i` high sets control bit 10 and clears the line's active bit. It delivers no byte, leaves the line's address and count unchanged, and does not set bit 15. A control write with bit 8 at 1 clears bit 10.
- R9: Offset 4 is the break mask. It reads back as written and drives `brk_o` directly. It does not affect the fetch engine.
- R10: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_ack_i`.
- R11: A line that is started with a count of zero finishes on its turn without a fetch: active bit cleared, bit 15 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 18 | Memory read byte address |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_err_i | input | 1 | Acknowledge carries a non-existent-memory error |
| mem_rdata_i | input | 8 | Read byte |
| tx_valid_o | output | 16 | Output slot holds a byte, one bit per line |
| tx_data_o | output | 128 | Output bytes, 8 bits per line |
| tx_ready_i | input | 16 | Serialiser accepts the byte, one bit per line |
| brk_o | output | 16 | Break (spacing) state per line |
| irq_o | output | 1 | Transmit interrupt |

## Verification
The assertions check, on every cycle, the properties that hold at any moment:
- the request stays stable until it is acknowledged;
- a slot fills only from a good acknowledge, and at most one slot fills per cycle;
- a filled slot holds until its ready;
- an error acknowledge sets the error flag and fills no slot;
- a request is raised only while some line is active.

Only the bench scenarios can show:
- the correct bytes in the correct order on each lane;
- the round-robin grant order across several lines;
- the final address and count after a normal end, a stop and an abort;
- the quick completion of a zero count;
- the register window keeping each line's values separate.

// File: rtl/mltx_pkg.sv
package mltx_pkg;
  localparam int REG_W = 16;
  localparam int LO_W  = 16;

  typedef enum logic [2:0] {
    RG_CTL  = 3'd0,
    RG_ADDR = 3'd1,
    RG_CNT  = 3'd2,
    RG_ACT  = 3'd3,
    RG_BRK  = 3'd4
  } reg_off_e;

  localparam int CTL_DONE    = 15;
  localparam int CTL_DONE_EN = 13;
  localparam int CTL_MERR    = 10;
  localparam int CTL_MERR_CL = 8;
  localparam int CTL_HI_LSB  = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_REQ  = 1'b1
  } eng_state_e;
endpackage

// File: rtl/mltx_rr_arb.sv
module mltx_rr_arb #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic             gnt_vld_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  always_comb begin
    int j;
    gnt_vld_o = 1'b0;
    gnt_idx_o = '0;
    // scan downwards so the lowest offset from ptr wins
    for (int k = N - 1; k >= 0; k--) begin
      j = (int'(ptr_i) + k) % N;
      if (req_i[j]) begin
        gnt_vld_o = 1'b1;
        gnt_idx_o = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/mltx_line_regs.sv
module mltx_line_regs #(
  parameter int N      = 16,
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 4,
  localparam int LO_W  = mltx_pkg::LO_W,
  localparam int HI_W  = ADDR_W - LO_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [IDX_W-1:0]             sel_i,
  input  logic                         sw_lo_we_i,
  input  logic [LO_W-1:0]              sw_lo_i,
  input  logic                         sw_hi_we_i,
  input  logic [IDX_W-1:0]             sw_hi_idx_i,
  input  logic [HI_W-1:0]              sw_hi_i,
  input  logic                         sw_cnt_we_i,
  input  logic [CNT_W-1:0]             sw_cnt_i,
  input  logic                         eng_we_i,
  input  logic [IDX_W-1:0]             eng_idx_i,
  input  logic [ADDR_W-1:0]            eng_addr_i,
  input  logic [CNT_W-1:0]             eng_cnt_i,
  output logic [N-1:0][ADDR_W-1:0]     addr_o,
  output logic [N-1:0][CNT_W-1:0]      cnt_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_o[i] <= '0;
        cnt_o[i]  <= '0;
      end else begin
        if (eng_we_i && eng_idx_i == IDX_W'(i)) begin
          addr_o[i] <= eng_addr_i;
          cnt_o[i]  <= eng_cnt_i;
        end
        // software writes take priority over the engine update
        if (sw_lo_we_i && sel_i == IDX_W'(i))
          addr_o[i][LO_W-1:0] <= sw_lo_i;
        if (sw_hi_we_i && sw_hi_idx_i == IDX_W'(i))
          addr_o[i][ADDR_W-1:LO_W] <= sw_hi_i;
        if (sw_cnt_we_i && sel_i == IDX_W'(i))
          cnt_o[i] <= sw_cnt_i;
      end
    end
  end
endmodule

// File: rtl/mltx_tx_slots.sv
module mltx_tx_slots #(
  parameter int N      = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [IDX_W-1:0]    load_idx_i,
  input  logic [DATA_W-1:0]   load_data_i,
  input  logic [N-1:0]        ready_i,
  output logic [N-1:0]        valid_o,
  output logic [N*DATA_W-1:0] data_o
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[i]                  <= 1'b0;
        data_o[i*DATA_W +: DATA_W]  <= '0;
      end else if (load_i && load_idx_i == IDX_W'(i)) begin
        valid_o[i]                  <= 1'b1;
        data_o[i*DATA_W +: DATA_W]  <= load_data_i;
      end else if (valid_o[i] && ready_i[i]) begin
        valid_o[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mltx_engine.sv
module mltx_engine #(
  parameter int N_LINES = 16,
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      reg_we_i,
  input  logic [2:0]                reg_addr_i,
  input  logic [15:0]               reg_wdata_i,
  output logic [15:0]               reg_rdata_o,
  output logic                      mem_req_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  input  logic                      mem_ack_i,
  input  logic                      mem_err_i,
  input  logic [DATA_W-1:0]         mem_rdata_i,
  output logic [N_LINES-1:0]        tx_valid_o,
  output logic [N_LINES*DATA_W-1:0] tx_data_o,
  input  logic [N_LINES-1:0]        tx_ready_i,
  output logic [N_LINES-1:0]        brk_o,
  output logic                      irq_o
);
  import mltx_pkg::*;

  localparam int SEL_W = $clog2(N_LINES);
  localparam int CNT_W = REG_W;
  localparam int HI_W  = ADDR_W - LO_W;
  localparam logic [SEL_W-1:0] LAST = SEL_W'(N_LINES - 1);

  logic [SEL_W-1:0]  sel_q, cur_q, ptr_q;
  logic              done_en_q, done_q, merr_q;
  logic [N_LINES-1:0] act_q, brk_q;
  eng_state_e        state_q, state_d;
  logic [ADDR_W-1:0] fetch_addr_q;

  logic wr_ctl, wr_addr, wr_cnt, wr_act, wr_brk;
  assign wr_ctl  = reg_we_i && reg_addr_i == RG_CTL;
  assign wr_addr = reg_we_i && reg_addr_i == RG_ADDR;
  assign wr_cnt  = reg_we_i && reg_addr_i == RG_CNT;
  assign wr_act  = reg_we_i && reg_addr_i == RG_ACT;
  assign wr_brk  = reg_we_i && reg_addr_i == RG_BRK;

  logic [N_LINES-1:0][ADDR_W-1:0] addr_w;
  logic [N_LINES-1:0][CNT_W-1:0]  cnt_w;

  logic              gnt_vld;
  logic [SEL_W-1:0]  gnt_idx;
  logic              eng_we, load, done_set, err_set;
  logic [ADDR_W-1:0] eng_addr;
  logic [CNT_W-1:0]  eng_cnt;
  logic [N_LINES-1:0] act_clr;

  mltx_line_regs #(
    .N(N_LINES), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(SEL_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel_q),
    .sw_lo_we_i  (wr_addr),
    .sw_lo_i     (reg_wdata_i[LO_W-1:0]),
    .sw_hi_we_i  (wr_ctl),
    .sw_hi_idx_i (reg_wdata_i[SEL_W-1:0]),
    .sw_hi_i     (reg_wdata_i[CTL_HI_LSB +: HI_W]),
    .sw_cnt_we_i (wr_cnt),
    .sw_cnt_i    (reg_wdata_i),
    .eng_we_i    (eng_we),
    .eng_idx_i   (cur_q),
    .eng_addr_i  (eng_addr),
    .eng_cnt_i   (eng_cnt),
    .addr_o      (addr_w),
    .cnt_o       (cnt_w)
  );

  mltx_rr_arb #(.N(N_LINES), .IDX_W(SEL_W)) u_arb (
    .req_i     (act_q & ~tx_valid_o),
    .ptr_i     (ptr_q),
    .gnt_vld_o (gnt_vld),
    .gnt_idx_o (gnt_idx)
  );

  mltx_tx_slots #(.N(N_LINES), .DATA_W(DATA_W), .IDX_W(SEL_W)) u_slots (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_idx_i  (cur_q),
    .load_data_i (mem_rdata_i),
    .ready_i     (tx_ready_i),
    .valid_o     (tx_valid_o),
    .data_o      (tx_data_o)
  );

  always_comb begin
    state_d  = state_q;
    eng_we   = 1'b0;
    load     = 1'b0;
    done_set = 1'b0;
    err_set  = 1'b0;
    act_clr  = '0;
    eng_addr = fetch_addr_q + ADDR_W'(1);
    eng_cnt  = cnt_w[cur_q] + CNT_W'(1);
    case (state_q)
      ST_IDLE: begin
        if (gnt_vld) begin
          if (cnt_w[gnt_idx] == '0) begin
            act_clr[gnt_idx] = 1'b1;
            done_set         = 1'b1;
          end else begin
            state_d = ST_REQ;
          end
        end
      end
      default: begin
        if (mem_ack_i) begin
          state_d = ST_IDLE;
          if (mem_err_i) begin
            act_clr[cur_q] = 1'b1;
            err_set        = 1'b1;
          end else begin
            load   = 1'b1;
            eng_we = 1'b1;
            if (eng_cnt == '0) begin
              act_clr[cur_q] = 1'b1;
              done_set       = 1'b1;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cur_q        <= '0;
      ptr_q        <= '0;
      fetch_addr_q <= '0;
      act_q        <= '0;
      brk_q        <= '0;
      sel_q        <= '0;
      done_en_q    <= 1'b0;
      done_q       <= 1'b0;
      merr_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && gnt_vld) begin
        cur_q        <= gnt_idx;
        ptr_q        <= (gnt_idx == LAST) ? '0 : gnt_idx + SEL_W'(1);
        fetch_addr_q <= addr_w[gnt_idx];
      end
      act_q <= (act_q & ~act_clr) | (wr_act ? reg_wdata_i[N_LINES-1:0] : '0);
      if (wr_brk) brk_q <= reg_wdata_i[N_LINES-1:0];
      if (wr_ctl) begin
        sel_q     <= reg_wdata_i[SEL_W-1:0];
        done_en_q <= reg_wdata_i[CTL_DONE_EN];
      end
      if (done_set)                               done_q <= 1'b1;
      else if (wr_ctl && !reg_wdata_i[CTL_DONE])  done_q <= 1'b0;
      if (err_set)                                merr_q <= 1'b1;
      else if (wr_ctl && reg_wdata_i[CTL_MERR_CL]) merr_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RG_CTL: begin
        reg_rdata_o[CTL_DONE]              = done_q;
        reg_rdata_o[CTL_DONE_EN]           = done_en_q;
        reg_rdata_o[CTL_MERR]              = merr_q;
        reg_rdata_o[CTL_HI_LSB +: HI_W]    = addr_w[sel_q][ADDR_W-1:LO_W];
        reg_rdata_o[SEL_W-1:0]             = sel_q;
      end
      RG_ADDR: reg_rdata_o = addr_w[sel_q][LO_W-1:0];
      RG_CNT:  reg_rdata_o = cnt_w[sel_q];
      RG_ACT:  reg_rdata_o[N_LINES-1:0] = act_q;
      RG_BRK:  reg_rdata_o[N_LINES-1:0] = brk_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assign mem_req_o  = state_q == ST_REQ;
  assign mem_addr_o = fetch_addr_q;
  assign brk_o      = brk_q;
  assign irq_o      = done_q & done_en_q;
endmodule

// File: rtl/mltx_engine_chk.sv
module mltx_engine_chk #(
  parameter int N      = 16,
  parameter int ADDR_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic              mem_err_i,
  input logic [N-1:0]      tx_valid_o,
  input logic [N-1:0]      tx_ready_i,
  input logic [N-1:0]      act_i,
  input logic              merr_i
);
  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  p_req_needs_active_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> act_i != '0);

  p_fill_from_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o & ~$past(tx_valid_o)) != '0 |-> $past(mem_req_o && mem_ack_i && !mem_err_i));

  p_one_fill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tx_valid_o & ~$past(tx_valid_o)) <= 1);

  p_slot_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tx_valid_o & ~tx_ready_i) & ~tx_valid_o) == '0);

  p_err_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && mem_err_i |=> merr_i);

  p_err_no_fill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && mem_err_i |=> (tx_valid_o & ~$past(tx_valid_o)) == '0);
endmodule

bind mltx_engine mltx_engine_chk #(.N(N_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_ack_i  (mem_ack_i),
  .mem_err_i  (mem_err_i),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .act_i      (act_q),
  .merr_i     (merr_q)
);

// File: tb/mltx_engine_tb.sv
module mltx_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic mem_req;
  logic [17:0] mem_addr;
  logic mem_ack = 1'b0;
  logic mem_err = 1'b0;
  logic [7:0] mem_rdata = '0;
  logic [N-1:0] tx_valid;
  logic [N*8-1:0] tx_data;
  logic [N-1:0] tx_ready = '1;
  logic [N-1:0] brk;
  logic irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  mltx_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_err_i(mem_err),
    .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .brk_o(brk), .irq_o(irq)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lat = 1;
  int wait_cnt = 0;
  logic [17:0] req_addr0 = '0;
  logic done_en_b = 1'b0;
  logic [7:0] exp_q [N][$];
  int fetch_log[$];
  int bytes_seen [N];

  task automatic chk(input string rq, input string what, input longint actv, input longint expv);
    checks++;
    if (actv != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, actv, expv);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {6'd0, a[17:16]} ^ 8'h5A;
  endfunction

  // memory responder; addresses with bits 17:16 == 3 are non-existent
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; mem_err = 1'b0; wait_cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0; mem_err = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt == 0) req_addr0 = mem_addr;
      else chk("R10", "request address stable", mem_addr, req_addr0);
      if (wait_cnt >= lat) begin
        mem_ack = 1'b1;
        mem_err = (mem_addr[17:16] == 2'b11);
        mem_rdata = mem_byte(mem_addr);
        fetch_log.push_back(int'(mem_addr[11:8]));
        wait_cnt = 0;
      end else wait_cnt++;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int n = 0; n < N; n++) begin
        if (tx_valid[n] && tx_ready[n]) begin
          bytes_seen[n]++;
          if (exp_q[n].size() == 0) begin
            chk("R3", $sformatf("unexpected byte line %0d", n), tx_data[n*8 +: 8], 0);
          end else begin
            chk("R3", $sformatf("byte line %0d", n), tx_data[n*8 +: 8], exp_q[n].pop_front());
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [15:0] ctl_word(input int line, input logic [1:0] hi, input bit keep_done);
    return {keep_done, 1'b0, done_en_b, 13'd0} | {10'd0, hi, 4'(line)};
  endfunction

  task automatic set_line(input int line, input logic [17:0] a, input logic [15:0] c);
    wr(3'd0, ctl_word(line, a[17:16], 1'b1));
    wr(3'd1, a[15:0]);
    wr(3'd2, c);
  endtask

  task automatic expect_bytes(input int line, input logic [17:0] a, input int n);
    for (int k = 0; k < n; k++) exp_q[line].push_back(mem_byte(a + 18'(k)));
  endtask

  task automatic wait_inactive(input int line, input string rq);
    logic [15:0] v;
    int t;
    t = 0;
    rd(3'd3, v);
    while (v[line] && t < 5000) begin
      rd(3'd3, v);
      t++;
    end
    chk(rq, $sformatf("line %0d finished", line), v[line], 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    int n_w, k;
    for (int n = 0; n < N; n++) bytes_seen[n] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1", $sformatf("reset reg %0d", a), v, 0);
    end
    chk("R1", "reset mem_req", mem_req, 0);
    chk("R1", "reset tx_valid", tx_valid, 0);
    chk("R1", "reset irq", irq, 0);
    chk("R1", "reset brk", brk, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 register window
    set_line(3, 18'h0_1234, 16'hFFFB);
    set_line(5, 18'h2_BEEF, 16'h8000);
    wr(3'd0, ctl_word(3, 2'd0, 1'b1));
    rd(3'd1, v); chk("R2", "line3 addr lo", v, 16'h1234);
    rd(3'd2, v); chk("R2", "line3 count", v, 16'hFFFB);
    rd(3'd0, v); chk("R2", "ctl sel/hi", v[5:0], 6'h03);
    wr(3'd0, ctl_word(5, 2'd2, 1'b1));
    rd(3'd1, v); chk("R2", "line5 addr lo", v, 16'hBEEF);
    rd(3'd2, v); chk("R2", "line5 count", v, 16'h8000);
    rd(3'd0, v); chk("R2", "line5 hi", v[5:4], 2);

    // R3/R4 single line transfer
    lat = 2;
    set_line(2, 18'h1_0200, 16'hFFFC);
    expect_bytes(2, 18'h1_0200, 4);
    wr(3'd3, 16'h0004);
    wait_inactive(2, "R4");
    chk("R3", "line2 all bytes", exp_q[2].size(), 0);
    rd(3'd1, v); chk("R3", "line2 addr advanced", v, 16'h0204);
    rd(3'd2, v); chk("R4", "line2 count zero", v, 0);
    rd(3'd0, v); chk("R4", "done flag", v[15], 1);
    chk("R2", "line2 hi bits", v[5:4], 1);
    chk("R4", "irq masked", irq, 0);
    done_en_b = 1'b1;
    wr(3'd0, ctl_word(2, 2'd1, 1'b1));
    chk("R4", "irq enabled", irq, 1);
    wr(3'd0, ctl_word(2, 2'd1, 1'b0));
    rd(3'd0, v); chk("R4", "done flag cleared", v[15], 0);
    chk("R4", "irq after clear", irq, 0);

    // R6 round robin across lines 0..2
    lat = 1;
    for (int l = 0; l < 3; l++) begin
      set_line(l, 18'(l << 8), 16'hFFFD);
      expect_bytes(l, 18'(l << 8), 3);
    end
    fetch_log.delete();
    wr(3'd3, 16'h0007);
    for (int l = 0; l < 3; l++) wait_inactive(l, "R6");
    chk("R6", "fetch count", fetch_log.size(), 9);
    for (int i = 0; i < 9 && i < fetch_log.size(); i++)
      chk("R6", $sformatf("grant %0d", i), fetch_log[i], i % 3);

    // R5 slot full blocks further fetches
    tx_ready[4] = 1'b0;
    set_line(4, 18'h0_0400, 16'hFFFD);
    expect_bytes(4, 18'h0_0400, 3);
    fetch_log.delete();
    wr(3'd3, 16'h0010);
    repeat (20) @(negedge clk);
    chk("R5", "one fetch while not ready", fetch_log.size(), 1);
    chk("R5", "slot held", tx_valid[4], 1);
    chk("R5", "held byte", tx_data[4*8 +: 8], mem_byte(18'h0_0400));
    tx_ready[4] = 1'b1;
    wait_inactive(4, "R5");
    chk("R5", "line4 all bytes", exp_q[4].size(), 0);

    // R7 stop by writing -1; R3 zero bits in active write are ignored
    lat = 3;
    set_line(6, 18'h0_0600, 16'hFF38);
    expect_bytes(6, 18'h0_0600, 200);
    bytes_seen[6] = 0;
    fetch_log.delete();
    wr(3'd3, 16'h0040);
    k = 0;
    while (fetch_log.size() < 5 && k < 2000) begin @(negedge clk); k++; end
    wr(3'd3, 16'h0000);
    rd(3'd3, v); chk("R3", "zero write keeps active", v[6], 1);
    wr(3'd2, 16'hFFFF);
    n_w = fetch_log.size();
    wait_inactive(6, "R7");
    k = bytes_seen[6];
    chk("R7", "stopped within one byte", (k >= n_w && k <= n_w + 1), 1);
    rd(3'd1, v); chk("R7", "addr shows progress", v, 16'h0600 + 16'(k));
    rd(3'd2, v); chk("R7", "count zero", v, 0);
    exp_q[6].delete();

    // R8 fetch error
    wr(3'd0, ctl_word(7, 2'd3, 1'b0));
    set_line(7, 18'h3_0700, 16'hFFFE);
    bytes_seen[7] = 0;
    wr(3'd3, 16'h0080);
    wait_inactive(7, "R8");
    rd(3'd0, v);
    chk("R8", "error flag", v[10], 1);
    chk("R8", "no done flag", v[15], 0);
    rd(3'd1, v); chk("R8", "addr unchanged", v, 16'h0700);
    rd(3'd2, v); chk("R8", "count unchanged", v, 16'hFFFE);
    chk("R8", "no byte delivered", bytes_seen[7], 0);
    wr(3'd0, ctl_word(7, 2'd3, 1'b1) | 16'h0100);
    rd(3'd0, v); chk("R8", "error flag cleared", v[10], 0);

    // R9 break mask
    wr(3'd4, 16'hA5A5);
    chk("R9", "brk output", brk, 16'hA5A5);
    rd(3'd4, v); chk("R9", "brk readback", v, 16'hA5A5);
    repeat (5) @(negedge clk);
    chk("R9", "no fetch from break", mem_req, 0);
    chk("R9", "no byte from break", tx_valid, 0);
    wr(3'd4, 16'h0000);
    chk("R9", "brk cleared", brk, 0);

    // R11 zero count
    set_line(9, 18'h0_0900, 16'h0000);
    wr(3'd0, ctl_word(9, 2'd0, 1'b0));
    fetch_log.delete();
    bytes_seen[9] = 0;
    wr(3'd3, 16'h0200);
    repeat (5) @(negedge clk);
    rd(3'd3, v); chk("R11", "zero count cleared", v[9], 0);
    chk("R11", "no fetch", fetch_log.size(), 0);
    rd(3'd0, v); chk("R11", "done flag", v[15], 1);
    chk("R11", "no byte", bytes_seen[9], 0);

    repeat (5) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule